// File: doc/BRIEF.md
# Trimmed One-Second Prescaler

This block turns a free-running 32.768 kHz timebase, presented as a clock enable on a faster system clock, into a one-cycle pulse once per second. It is the seconds source for a clock/calendar. It also corrects the long-term rate of a crystal that is slightly fast or slow. A small signed code selects a correction of 0 to 60 ppm in 20 ppm steps. The correction lengthens or shortens individual seconds by whole timebase counts, so the input frequency is never touched.

Each step is worth 0.65536 counts per second, so a fractional accumulator decides at every second boundary how many whole counts the next second gains or loses. The accumulated error never reaches one count. Over many seconds the average period matches the requested correction exactly. The binary value of the divider is brought out as taps for logic that needs sub-second phase. A new code is sampled only at a second boundary, so the second that is in progress always completes with the setting it started with.

Top module: `trim_prescaler`

## Requirements
- R1: While `rst` is high, `tick` is 0 and `taps` is 0. After `rst` falls, the first `tick` arrives after exactly 2^DIV_LOG2 enabled cycles, whatever `trim_code` holds, because the active code is cleared to 0 by reset.
- R2: With a magnitude of 0 (codes 0 and 4), every second lasts exactly 2^DIV_LOG2 enabled cycles.
- R3: The divider advances only in cycles where `ce` is 1. `tick` is high for exactly one clock cycle, the cycle after the enabled cycle that ends a second.
- R4: Code encoding: bit 2 set means speed up, which shortens seconds. Bit 2 clear means slow down, which lengthens seconds. Bits 1:0 give the magnitude m, in 20 ppm steps.
- R5: After S seconds under magnitude m, counted from an accumulator value of zero, the total length differs from S·2^DIV_LOG2 by exactly floor(S·m·STEP_NUM/STEP_DEN) counts. The difference is shorter when bit 2 is 1 and longer when it is 0.
- R6: Corrections are applied only by moving the terminal count. Each second differs from 2^DIV_LOG2 by at most floor((STEP_DEN−1+m·STEP_NUM)/STEP_DEN) counts: 1 for m=1, and 2 for m=2 or m=3. The counter never passes the terminal value.
- R7: `trim_code` is sampled only at a second boundary. A change in mid-second leaves the current second's length unchanged.
- R8: Reset clears the fractional accumulator, and the accumulator always stays below STEP_DEN. A run after reset therefore repeats R5 exactly, whatever history came before.
- R9: `taps` holds the number of enabled cycles since the last second boundary, in binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | One-cycle enable at the timebase rate (32.768 kHz) |
| trim_code | input | TRIM_W | Rate correction code: bit 2 is the direction, bits 1:0 the magnitude |
| tick | output | 1 | One-cycle pulse at each second boundary |
| taps | output | DIV_LOG2 | Enabled-cycle count within the current second |

## Verification
The assertions check on every cycle the following:
- the counter stays at or below its terminal value;
- the remainder stays below one count, and the per-second correction stays within its bound;
- the active code stays still between boundaries;
- `tick` is one cycle wide and follows an enabled cycle;
- reset leaves the accumulator at zero.

The exact long-term correction for each of the eight codes, the direction of each correction, and the per-second deviation limits can only be shown by the bench. It measures many consecutive seconds and compares the total with the closed-form count. The same applies to the deferred effect of a mid-second code change and to the gated-enable period.

// File: rtl/prescale_pkg.sv
package prescale_pkg;

  typedef enum logic {
    DIR_SLOW = 1'b0,
    DIR_FAST = 1'b1
  } trim_dir_e;

  // Largest whole-count correction in one second for magnitude mag,
  // given a remainder strictly below den.
  function automatic int unsigned max_corr(int unsigned mag,
                                           int unsigned num,
                                           int unsigned den);
    return (den - 1 + mag * num) / den;
  endfunction

  function automatic int unsigned width_of(int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/trim_decode.sv
module trim_decode
  import prescale_pkg::*;
#(
  parameter int TRIM_W = 3,
  localparam int MAG_W = TRIM_W - 1
) (
  input  logic [TRIM_W-1:0] code,
  output trim_dir_e         dir,
  output logic [MAG_W-1:0]  mag
);

  assign dir = trim_dir_e'(code[TRIM_W-1]);
  assign mag = code[MAG_W-1:0];

endmodule

// File: rtl/trim_accum.sv
module trim_accum
  import prescale_pkg::*;
#(
  parameter int MAG_W    = 2,
  parameter int STEP_NUM = 65536,
  parameter int STEP_DEN = 100000,
  parameter int K_MAX    = 2,
  parameter int K_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [MAG_W-1:0] mag,
  output logic [K_W-1:0]   corr_q
);

  localparam int MAX_MAG = (1 << MAG_W) - 1;
  localparam int ACC_W   = $clog2(STEP_DEN + MAX_MAG * STEP_NUM + 1);
  localparam logic [ACC_W-1:0] NUM_V = ACC_W'(STEP_NUM);
  localparam logic [ACC_W-1:0] DEN_V = ACC_W'(STEP_DEN);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] rem;
  logic [K_W-1:0]   corr_n;

  // Fold the new fraction in and strip out whole counts.
  always_comb begin
    rem    = acc_q + ACC_W'(mag) * NUM_V;
    corr_n = '0;
    for (int i = 0; i < K_MAX; i++) begin
      if (rem >= DEN_V) begin
        rem    = rem - DEN_V;
        corr_n = corr_n + K_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      corr_q <= '0;
    end else if (load) begin
      acc_q  <= rem;
      corr_q <= corr_n;
    end
  end

  assert_acc_below_den_R8: assert property (@(posedge clk) disable iff (rst)
    acc_q < DEN_V)
    else $error("fractional remainder reached a whole count");

  assert_acc_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (acc_q == '0))
    else $error("accumulator not cleared by reset");

  assert_corr_bound_R6: assert property (@(posedge clk) disable iff (rst)
    int'(corr_q) <= K_MAX)
    else $error("per-second correction exceeds bound");

endmodule

// File: rtl/div_counter.sv
module div_counter
  import prescale_pkg::*;
#(
  parameter int DIV_LOG2 = 15,
  parameter int K_W      = 2,
  localparam int CNT_W   = DIV_LOG2 + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ce,
  input  trim_dir_e           dir_q,
  input  logic [K_W-1:0]      corr_q,
  output logic                wrap,
  output logic                tick,
  output logic [DIV_LOG2-1:0] taps
);

  localparam logic [CNT_W-1:0] BASE_TERM = CNT_W'((1 << DIV_LOG2) - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;

  assign term = (dir_q == DIR_FAST) ? BASE_TERM - CNT_W'(corr_q)
                                    : BASE_TERM + CNT_W'(corr_q);
  assign wrap = ce && (cnt_q >= term);
  assign taps = cnt_q[DIV_LOG2-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= wrap;
      if (wrap)    cnt_q <= '0;
      else if (ce) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= term)
    else $error("counter passed terminal value");

  assert_tick_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick)
    else $error("tick wider than one cycle");

  assert_tick_after_ce_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(tick) |-> $past(ce))
    else $error("tick without enabled cycle");

  assert_hold_without_ce_R3: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(cnt_q))
    else $error("counter moved without enable");

endmodule

// File: rtl/trim_prescaler.sv
module trim_prescaler
  import prescale_pkg::*;
#(
  parameter int DIV_LOG2 = 15,
  parameter int TRIM_W   = 3,
  parameter int STEP_NUM = 65536,
  parameter int STEP_DEN = 100000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ce,
  input  logic [TRIM_W-1:0]   trim_code,
  output logic                tick,
  output logic [DIV_LOG2-1:0] taps
);

  localparam int MAG_W   = TRIM_W - 1;
  localparam int MAX_MAG = (1 << MAG_W) - 1;
  localparam int K_MAX   = int'(max_corr(MAX_MAG, STEP_NUM, STEP_DEN));
  localparam int K_W     = int'(width_of(K_MAX));

  trim_dir_e         dir_in;
  trim_dir_e         dir_q;
  logic [MAG_W-1:0]  mag_in;
  logic [K_W-1:0]    corr_q;
  logic [TRIM_W-1:0] trim_q;
  logic              wrap;

  trim_decode #(.TRIM_W(TRIM_W)) u_decode (
    .code (trim_code),
    .dir  (dir_in),
    .mag  (mag_in)
  );

  // Active code is captured only at a second boundary.
  always_ff @(posedge clk) begin
    if (rst) begin
      trim_q <= '0;
      dir_q  <= DIR_SLOW;
    end else if (wrap) begin
      trim_q <= trim_code;
      dir_q  <= dir_in;
    end
  end

  trim_accum #(
    .MAG_W    (MAG_W),
    .STEP_NUM (STEP_NUM),
    .STEP_DEN (STEP_DEN),
    .K_MAX    (K_MAX),
    .K_W      (K_W)
  ) u_accum (
    .clk    (clk),
    .rst    (rst),
    .load   (wrap),
    .mag    (mag_in),
    .corr_q (corr_q)
  );

  div_counter #(
    .DIV_LOG2 (DIV_LOG2),
    .K_W      (K_W)
  ) u_count (
    .clk    (clk),
    .rst    (rst),
    .ce     (ce),
    .dir_q  (dir_q),
    .corr_q (corr_q),
    .wrap   (wrap),
    .tick   (tick),
    .taps   (taps)
  );

  assert_code_held_R7: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(trim_q))
    else $error("active code changed inside a second");

  assert_zero_mag_no_corr_R2: assert property (@(posedge clk) disable iff (rst)
    (trim_q[MAG_W-1:0] == '0) |-> (corr_q == '0))
    else $error("correction applied with zero magnitude");

endmodule

// File: tb/tb_trim_prescaler.sv
`timescale 1ns/1ps
module tb_trim_prescaler;

  localparam int L    = 6;
  localparam int T    = 1 << L;
  localparam int NUM  = 65536;
  localparam int DEN  = 100000;
  localparam int SECS = 40;

  logic         clk = 0;
  logic         rst = 1;
  logic         ce  = 0;
  logic [2:0]   trim_code = 0;
  logic         tick;
  logic [L-1:0] taps;

  int checks = 0;
  int fails  = 0;
  int ce_gap = 1;
  int ph     = 0;

  always #10 clk = ~clk;

  trim_prescaler #(.DIV_LOG2(L), .TRIM_W(3), .STEP_NUM(NUM), .STEP_DEN(DEN)) dut (
    .clk(clk), .rst(rst), .ce(ce), .trim_code(trim_code), .tick(tick), .taps(taps)
  );

  always @(negedge clk) begin
    ph = (ph + 1) % ce_gap;
    ce = (ph == 0);
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  // Counts negedges until tick is seen high; 0 on timeout.
  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 2000);
    if (!tick) begin
      check(0, "watchdog tick", n, 0);
      n = 0;
    end
  endtask

  task automatic test_reset();
    int n;
    ce_gap = 1;
    trim_code = 3'd7;
    @(negedge clk);
    rst = 1;
    repeat (3) @(negedge clk);
    check(tick == 0 && taps == 0, "R1 reset outputs", {tick, taps}, 0);
    rst = 0;
    repeat (37) @(negedge clk);
    check(taps == 37, "R9 taps count", taps, 37);
    wait_tick(n);
    check(n + 37 == T, "R1 first tick", n + 37, T);
  endtask

  task automatic test_gated();
    int n;
    ce_gap = 3;
    trim_code = 3'd0;
    do_reset();
    wait_tick(n);
    wait_tick(n);
    check(n == 3 * T, "R3 gated period", n, 3 * T);
    @(negedge clk);
    check(tick == 0, "R3 tick width", tick, 0);
    ce_gap = 1;
  endtask

  // Runs SECS trimmed seconds and checks total and per-second bounds.
  task automatic run_secs(input int code, input string tag);
    int     p;
    longint total = 0;
    int     m = code & 3;
    bit     fast = code[2];
    longint corr = (longint'(SECS) * m * NUM) / DEN;
    longint expv = fast ? SECS * T - corr : SECS * T + corr;
    int     kb = (DEN - 1 + m * NUM) / DEN;
    bit     bad = 0;
    int     worst = 0;
    for (int s = 0; s < SECS; s++) begin
      wait_tick(p);
      total += p;
      if (fast ? (p > T || T - p > kb) : (p < T || p - T > kb)) begin
        bad = 1;
        worst = p;
      end
    end
    check(total == expv, {tag, " R5 total"}, total, expv);
    check(!bad, {tag, " R4 R6 per-second"}, worst, T);
  endtask

  task automatic test_code(input int code);
    int n;
    trim_code = 3'(code);
    do_reset();
    wait_tick(n);
    check(n == T, "R2 first second untrimmed", n, T);
    run_secs(code, (code[1:0] == 0) ? "R2 zero magnitude" : "R4 code");
  endtask

  task automatic test_change();
    int n;
    trim_code = 3'd0;
    do_reset();
    wait_tick(n);
    repeat (20) @(negedge clk);
    trim_code = 3'd7;
    wait_tick(n);
    check(n + 20 == T, "R7 mid-second change deferred", n + 20, T);
    run_secs(7, "R7 after boundary");
  endtask

  task automatic test_reset_clears();
    int n;
    trim_code = 3'd3;
    do_reset();
    for (int s = 0; s < 8; s++) wait_tick(n);
    repeat (11) @(negedge clk);
    do_reset();
    wait_tick(n);
    check(n == T, "R8 first second after reset", n, T);
    run_secs(3, "R8 accumulator cleared");
  endtask

  initial begin
    #2ms;
    check(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_gated();
    for (int c = 0; c < 8; c++) test_code(c);
    test_change();
    test_reset_clears();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule